// File: doc/BRIEF.md
# Secondary Bus Reset Generator

This block drives the active-low reset of the downstream bus behind a PCI-to-PCI bridge. The downstream reset goes active at once, with no clock involved, whenever the upstream reset is active or software sets the bus-reset control bit. It is released only on a rising edge of the secondary clock, after a short synchronising delay. The upstream and downstream sides keep independent reset states: the software bit resets only the downstream bus, and it leaves the bridge's own status untouched.

When software sets the bus-reset bit and later clears it, the block records the event in a sticky status flag. Software clears the flag by writing one to it. The flag also drives an interrupt request when the enable bit allows it. While the downstream reset is active, the block asks the downstream arbiter to park the bus on the bridge. The block has no input that watches the downstream reset line, so another device that pulls that line low causes no action here. Register decoding and the arbiter lie outside the block.

Top module: `sec_rst_gen`

## Requirements
- R1: While `up_rst_n` is 0, `sec_rst_n` is 0 through a combinational path that needs no clock edge.
- R2: While `ctl_bus_rst` is 1, `sec_rst_n` is 0 through a combinational path that needs no clock edge.
- R3: Once `up_rst_n` is 1 and `ctl_bus_rst` is 0, `sec_rst_n` stays 0 through the first rising edge of `clk_s` and becomes 1 at the second rising edge (SYNC_STAGES = 2).
- R4: `park_req` is 1 exactly while `sec_rst_n` is 0. It therefore rises with no clock delay when the upstream reset is asserted.
- R5: When `up_rst_n` is 1 and `ctl_bus_rst` is seen as 1 at one rising edge and 0 at the next, `rst_flag` becomes 1 at that next edge.
- R6: `rst_flag` holds its value until a rising edge with `flag_clr` = 1 clears it. If a new set event from R5 falls on the same edge, the set wins and the flag stays 1.
- R7: `irq` equals `rst_flag` AND `irq_en` at all times.
- R8: `up_rst_n` = 0 clears `rst_flag` and the sampled bus-reset bit at once. A 1-to-0 change of `ctl_bus_rst` that happens while `up_rst_n` is 0 does not set the flag after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Secondary bus clock |
| up_rst_n | input | 1 | Upstream reset, active low |
| ctl_bus_rst | input | 1 | Software bus-reset control bit, 1 = reset the downstream bus |
| irq_en | input | 1 | Interrupt enable for the reset-done flag |
| flag_clr | input | 1 | Write-one-to-clear strobe for `rst_flag`, sampled on `clk_s` |
| sec_rst_n | output | 1 | Downstream bus reset, active low |
| rst_flag | output | 1 | Sticky flag: the software bus reset was set and then cleared |
| irq | output | 1 | Interrupt request |
| park_req | output | 1 | Request to park the downstream bus on the bridge |

## Verification
The downstream reset is driven from each source in turn. The upstream reset is pulled low halfway through a clock period and is checked before the next edge, which separates a combinational assertion from a clocked one. The release is sampled after the first and after the second rising edge, which separates a two-stage release from a one-stage release or an immediate one. The flag is tried with three patterns: a plain software pulse, a clear strobe that lands on the same edge as a new set event (this separates set-wins from clear-wins priority), and a bit drop that happens while the upstream reset is held. The last pattern separates the upstream-only reset of the flag logic from the downstream reset.

// File: rtl/sec_rst_gen.sv
module sec_rst_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_s,
  input  logic up_rst_n,
  input  logic ctl_bus_rst,
  input  logic irq_en,
  input  logic flag_clr,
  output logic sec_rst_n,
  output logic rst_flag,
  output logic irq,
  output logic park_req
);

  logic                   rst_req;
  logic [SYNC_STAGES-1:0] rel_q;
  logic                   bit_q;
  logic                   flag_q;

  assign rst_req = ~up_rst_n | ctl_bus_rst;

  always_ff @(posedge clk_s or posedge rst_req) begin
    if (rst_req) rel_q <= '0;
    else         rel_q <= {rel_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign sec_rst_n = rel_q[SYNC_STAGES-1] & ~rst_req;
  assign park_req  = ~sec_rst_n;

  always_ff @(posedge clk_s or negedge up_rst_n) begin
    if (!up_rst_n) begin
      bit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      bit_q <= ctl_bus_rst;
      if (bit_q && !ctl_bus_rst) flag_q <= 1'b1;
      else if (flag_clr)         flag_q <= 1'b0;
    end
  end

  assign rst_flag = flag_q;
  assign irq      = flag_q & irq_en;

endmodule

// File: rtl/sec_rst_gen_chk.sv
module sec_rst_gen_chk (
  input logic clk_s,
  input logic up_rst_n,
  input logic ctl_bus_rst,
  input logic flag_clr,
  input logic sec_rst_n,
  input logic rst_flag
);

  p_up_assert_r1: assert property (@(negedge clk_s)
    !up_rst_n |-> !sec_rst_n);

  p_sw_assert_r2: assert property (@(negedge clk_s) disable iff (!up_rst_n)
    ctl_bus_rst |-> !sec_rst_n);

  p_release_r3: assert property (@(posedge clk_s) disable iff (!up_rst_n)
    $rose(sec_rst_n) |-> (!ctl_bus_rst && !$past(ctl_bus_rst) && $past(up_rst_n)));

  p_flag_set_r5: assert property (@(posedge clk_s) disable iff (!up_rst_n)
    ($past(up_rst_n) && $past(ctl_bus_rst) && !ctl_bus_rst) |=> rst_flag);

  p_flag_hold_r6: assert property (@(posedge clk_s) disable iff (!up_rst_n)
    (rst_flag && !flag_clr) |=> rst_flag);

  p_flag_clr_r6: assert property (@(posedge clk_s) disable iff (!up_rst_n)
    (flag_clr && !($past(up_rst_n) && $past(ctl_bus_rst) && !ctl_bus_rst)) |=> !rst_flag);

  p_flag_reset_r8: assert property (@(negedge clk_s)
    !up_rst_n |-> !rst_flag);

endmodule

bind sec_rst_gen sec_rst_gen_chk u_chk (
  .clk_s(clk_s), .up_rst_n(up_rst_n), .ctl_bus_rst(ctl_bus_rst),
  .flag_clr(flag_clr), .sec_rst_n(sec_rst_n), .rst_flag(rst_flag)
);

// File: tb/sec_rst_gen_test.sv
`timescale 1ns/1ps
module sec_rst_gen_test;
  logic clk_s = 1'b0;
  logic up_rst_n, ctl_bus_rst, irq_en, flag_clr;
  logic sec_rst_n, rst_flag, irq, park_req;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_s = ~clk_s;

  sec_rst_gen uut (
    .clk_s(clk_s), .up_rst_n(up_rst_n), .ctl_bus_rst(ctl_bus_rst),
    .irq_en(irq_en), .flag_clr(flag_clr), .sec_rst_n(sec_rst_n),
    .rst_flag(rst_flag), .irq(irq), .park_req(park_req)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_s);
    @(negedge clk_s);
    #1;
  endtask

  task automatic t_reset();
    up_rst_n = 1'b0; ctl_bus_rst = 1'b0; irq_en = 1'b0; flag_clr = 1'b0;
    #1;
    chk("R1", "sec_rst_n in upstream reset", sec_rst_n, 1'b0);
    chk("R4", "park_req in upstream reset", park_req, 1'b1);
    tick(); tick();
    chk("R8", "flag in upstream reset", rst_flag, 1'b0);
    chk("R7", "irq in upstream reset", irq, 1'b0);
  endtask

  task automatic t_release();
    up_rst_n = 1'b1;
    tick();
    chk("R3", "low after first edge", sec_rst_n, 1'b0);
    tick();
    chk("R3", "high after second edge", sec_rst_n, 1'b1);
    chk("R4", "park dropped", park_req, 1'b0);
  endtask

  task automatic t_async_up();
    #3 up_rst_n = 1'b0;
    #1;
    chk("R1", "combinational assert", sec_rst_n, 1'b0);
    chk("R4", "park without clock", park_req, 1'b1);
    tick();
    up_rst_n = 1'b1;
    tick(); tick();
    chk("R3", "released again", sec_rst_n, 1'b1);
  endtask

  task automatic t_sw_pulse();
    ctl_bus_rst = 1'b1;
    #1;
    chk("R2", "combinational sw assert", sec_rst_n, 1'b0);
    tick(); tick(); tick();
    chk("R5", "no flag while held", rst_flag, 1'b0);
    ctl_bus_rst = 1'b0;
    tick();
    chk("R5", "flag set on drop", rst_flag, 1'b1);
    chk("R3", "sw release first edge", sec_rst_n, 1'b0);
    chk("R7", "irq masked", irq, 1'b0);
    tick();
    chk("R3", "sw release second edge", sec_rst_n, 1'b1);
    irq_en = 1'b1;
    #1;
    chk("R7", "irq enabled", irq, 1'b1);
    tick(); tick();
    chk("R6", "flag holds", rst_flag, 1'b1);
  endtask

  task automatic t_set_wins();
    ctl_bus_rst = 1'b1;
    tick();
    ctl_bus_rst = 1'b0; flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk("R6", "set wins over clear", rst_flag, 1'b1);
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk("R6", "cleared by strobe", rst_flag, 1'b0);
    chk("R7", "irq follows clear", irq, 1'b0);
    tick();
    chk("R6", "stays clear", rst_flag, 1'b0);
  endtask

  task automatic t_up_clears();
    ctl_bus_rst = 1'b1;
    tick();
    ctl_bus_rst = 1'b0;
    tick();
    chk("R5", "flag set again", rst_flag, 1'b1);
    #3 up_rst_n = 1'b0;
    #1;
    chk("R8", "upstream clears flag", rst_flag, 1'b0);
    tick();
    ctl_bus_rst = 1'b1;
    tick();
    ctl_bus_rst = 1'b0;
    tick();
    up_rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R8", "drop in reset ignored", rst_flag, 1'b0);
    chk("R3", "released after upstream", sec_rst_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_release();
    t_async_up();
    t_sw_pulse();
    t_set_wins();
    t_up_clears();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule